// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter Stage

This block is one stage of a synchronous up-counter, four bits wide by default. Every bit of the count updates on the same rising clock edge. An active-low clear acts at once and does not wait for a clock edge. An active-low load copies a data word into the count on the next edge. Counting needs two enables. The first, the count enable, only gates the increment. The second, the chain enable, also gates the increment and in addition qualifies the terminal-count output.

To build a wider counter, connect several stages. All stages share the clock, the clear, the load and the count enable. The terminal-count output of each stage drives the chain enable of the next stage. The chained counter then advances as one wide synchronous register and needs no extra gates. The parameter `LOOKAHEAD` picks how the bit toggles are formed: as per-bit AND terms or as a serial chain. The function is the same either way.

Top module: `sync_count_stage`

## Requirements
- R1: While `clear_ni` is low, `count_o` is all zeros without waiting for a clock edge. This holds whatever the levels of the clock, `load_ni`, `cnt_en_i` and `chain_en_i`.
- R2: With `clear_ni` high and `load_ni` low, the next rising edge copies `data_i` into `count_o`, whatever the enable levels are. No counting takes place in that cycle.
- R3: With `clear_ni` and `load_ni` high and both `cnt_en_i` and `chain_en_i` high, each rising edge raises `count_o` by exactly one, and all bits change on that same edge.
- R4: An enabled increment from the all-ones value (4'b1111 at the default width) gives all zeros on that edge.
- R5: With `clear_ni` and `load_ni` high and either enable low, `count_o` keeps its value across the edge.
- R6: `carry_o` is high exactly when `chain_en_i` is high and `count_o` is all ones. It follows these inputs combinationally, and `cnt_en_i` has no effect on it.
- R7: In a chain of three default stages, each stage's `carry_o` drives the next stage's `chain_en_i`. The 12-bit concatenated count then increments synchronously and rolls over from 12'hFFF to 12'h000 on a single clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| clear_ni | input | 1 | Asynchronous clear, active low |
| load_ni | input | 1 | Synchronous parallel load, active low |
| data_i | input | WIDTH | Value loaded into the count |
| cnt_en_i | input | 1 | Count enable, gates counting only |
| chain_en_i | input | 1 | Chain enable, gates counting and qualifies `carry_o` |
| count_o | output | WIDTH | Current count |
| carry_o | output | 1 | Terminal count (all ones while `chain_en_i` is high) |

## Verification
A wrong toggle term shows up on `count_o` on the first enabled edge that reaches the bad bit position. A stuck load or stuck hold shows up one edge after the stimulus. A wrong terminal-count term shows up on `carry_o` in the same cycle, because no register lies in its path. In a chain, that same fault appears one edge later as a missed or extra advance of the upper stage, and this is most visible at the 12'hFFF rollover. The bench model predicts every cycle, so any divergence is reported within one clock.

// File: rtl/bcnt_pkg.sv
package bcnt_pkg;

   // Operation chosen for the coming edge, lowest priority first
   typedef enum logic [1:0] {
      ST_HOLD = 2'd0,
      ST_STEP = 2'd1,
      ST_LOAD = 2'd2
   } step_e;

endpackage

// File: rtl/bcnt_mode_dec.sv
module bcnt_mode_dec
   import bcnt_pkg::*;
(
   input  logic  load_ni,
   input  logic  cnt_en_i,
   input  logic  chain_en_i,
   output step_e op_o
);

   // Load outranks counting; counting outranks holding
   always_comb begin
      if (!load_ni)                     op_o = ST_LOAD;
      else if (cnt_en_i && chain_en_i)  op_o = ST_STEP;
      else                              op_o = ST_HOLD;
   end

endmodule

// File: rtl/bcnt_incr.sv
module bcnt_incr #(
   parameter int W         = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic [W-1:0] cur_i,
   output logic [W-1:0] nxt_o,
   output logic         full_o
);

   logic [W-1:0] tgl;

   // The lowest bit always toggles on a step
   assign tgl[0] = 1'b1;

   generate
      if (LOOKAHEAD) begin : g_look
         // Each toggle term is a wide AND of every lower bit
         for (genvar i = 1; i < W; i++) begin : g_bit
            assign tgl[i] = &cur_i[i-1:0];
         end
      end else begin : g_serial
         // Each toggle term extends the previous one by one gate
         for (genvar i = 1; i < W; i++) begin : g_bit
            assign tgl[i] = tgl[i-1] & cur_i[i-1];
         end
      end
   endgenerate

   assign nxt_o  = cur_i ^ tgl;
   assign full_o = tgl[W-1] & cur_i[W-1];

endmodule

// File: rtl/bcnt_bank.sv
module bcnt_bank
   import bcnt_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk_i,
   input  logic         clear_ni,
   input  step_e        op_i,
   input  logic [W-1:0] load_val_i,
   input  logic [W-1:0] step_val_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] d;

   always_comb begin
      unique case (op_i)
         ST_LOAD: d = load_val_i;
         ST_STEP: d = step_val_i;
         default: d = q_o;
      endcase
   end

   always_ff @(posedge clk_i or negedge clear_ni) begin
      if (!clear_ni) q_o <= '0;
      else           q_o <= d;
   end

endmodule

// File: rtl/sync_count_stage.sv
module sync_count_stage
   import bcnt_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic             clk_i,
   input  logic             clear_ni,
   input  logic             load_ni,
   input  logic [WIDTH-1:0] data_i,
   input  logic             cnt_en_i,
   input  logic             chain_en_i,
   output logic [WIDTH-1:0] count_o,
   output logic             carry_o
);

   localparam int MaxWidth = 64;

   generate
      if (WIDTH < 1 || WIDTH > MaxWidth) begin : g_bad_width
         $error("sync_count_stage: WIDTH out of range");
      end
   endgenerate

   step_e            op;
   logic [WIDTH-1:0] step_val;
   logic             full;

   bcnt_mode_dec u_dec (
      .load_ni    (load_ni),
      .cnt_en_i   (cnt_en_i),
      .chain_en_i (chain_en_i),
      .op_o       (op)
   );

   bcnt_incr #(.W(WIDTH), .LOOKAHEAD(LOOKAHEAD)) u_incr (
      .cur_i  (count_o),
      .nxt_o  (step_val),
      .full_o (full)
   );

   bcnt_bank #(.W(WIDTH)) u_bank (
      .clk_i      (clk_i),
      .clear_ni   (clear_ni),
      .op_i       (op),
      .load_val_i (data_i),
      .step_val_i (step_val),
      .q_o        (count_o)
   );

   // Terminal count: no register, so the next stage sees it in the same cycle
   assign carry_o = chain_en_i & full;

endmodule

// File: rtl/bcnt_chk.sv
module bcnt_chk #(
   parameter int W = 4
) (
   input logic         clk_i,
   input logic         clear_ni,
   input logic         load_ni,
   input logic [W-1:0] data_i,
   input logic         cnt_en_i,
   input logic         chain_en_i,
   input logic [W-1:0] count_o,
   input logic         carry_o
);

   // R1
   clear_zero_chk: assert property (@(posedge clk_i)
      !clear_ni |-> count_o == '0);

   // R2
   load_copy_chk: assert property (@(posedge clk_i) disable iff (!clear_ni)
      !load_ni |=> count_o == $past(data_i));

   // R3
   step_one_chk: assert property (@(posedge clk_i) disable iff (!clear_ni)
      (load_ni && cnt_en_i && chain_en_i) |=> count_o == W'($past(count_o) + 1'b1));

   // R5
   hold_val_chk: assert property (@(posedge clk_i) disable iff (!clear_ni)
      (load_ni && !(cnt_en_i && chain_en_i)) |=> $stable(count_o));

   // R6
   carry_term_chk: assert property (@(posedge clk_i) disable iff (!clear_ni)
      carry_o == (chain_en_i && (count_o == {W{1'b1}})));

endmodule

bind sync_count_stage bcnt_chk #(.W(WIDTH)) u_chk (
   .clk_i      (clk_i),
   .clear_ni   (clear_ni),
   .load_ni    (load_ni),
   .data_i     (data_i),
   .cnt_en_i   (cnt_en_i),
   .chain_en_i (chain_en_i),
   .count_o    (count_o),
   .carry_o    (carry_o)
);

// File: tb/tb_sync_count_stage.sv
module tb_sync_count_stage;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   // single stage
   logic       clr_n, ld_n, p, t;
   logic [3:0] d;
   logic [3:0] q;
   logic       co;

   sync_count_stage dut (
      .clk_i(clk), .clear_ni(clr_n), .load_ni(ld_n), .data_i(d),
      .cnt_en_i(p), .chain_en_i(t), .count_o(q), .carry_o(co)
   );

   // 12-bit chain of three stages, the middle one using the serial variant
   logic        c_ld_n, c_p, c_t;
   logic [11:0] c_d;
   logic [3:0]  q0, q1, q2;
   logic        k0, k1, k2;

   sync_count_stage s0 (.clk_i(clk), .clear_ni(clr_n), .load_ni(c_ld_n), .data_i(c_d[3:0]),
      .cnt_en_i(c_p), .chain_en_i(c_t), .count_o(q0), .carry_o(k0));
   sync_count_stage #(.LOOKAHEAD(1'b0)) s1 (.clk_i(clk), .clear_ni(clr_n), .load_ni(c_ld_n),
      .data_i(c_d[7:4]), .cnt_en_i(c_p), .chain_en_i(k0), .count_o(q1), .carry_o(k1));
   sync_count_stage s2 (.clk_i(clk), .clear_ni(clr_n), .load_ni(c_ld_n), .data_i(c_d[11:8]),
      .cnt_en_i(c_p), .chain_en_i(k1), .count_o(q2), .carry_o(k2));

   int    checks = 0;
   int    fails  = 0;
   int    m_cnt  = 0;
   int    m_chain = 0;
   string tag    = "R1";
   string c_tag  = "R7";
   bit    active = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural reference: priority clear, load, step, hold
   always @(negedge clr_n) begin
      m_cnt = 0;
      m_chain = 0;
   end

   always @(posedge clk) begin
      if (!clr_n) begin
         m_cnt = 0; tag = "R1";
      end else if (!ld_n) begin
         m_cnt = int'(d); tag = "R2";
      end else if (p && t) begin
         tag = (m_cnt == 15) ? "R4" : "R3";
         m_cnt = (m_cnt + 1) % 16;
      end else begin
         tag = "R5";
      end
      if (!clr_n)                m_chain = 0;
      else if (!c_ld_n)          m_chain = int'(c_d);
      else if (c_p && c_t)       m_chain = (m_chain + 1) % 4096;
      c_tag = "R7";
   end

   // compare away from the edge
   always @(posedge clk) begin
      #5;
      if (active) begin
         chk(q == 4'(m_cnt), tag, int'(q), m_cnt);
         chk(co == (t && m_cnt == 15), "R6", int'(co), int'(t && m_cnt == 15));
         chk({q2, q1, q0} == 12'(m_chain), c_tag, int'({q2, q1, q0}), m_chain);
         chk(k2 == (c_t && m_chain == 4095), "R7", int'(k2), int'(c_t && m_chain == 4095));
      end
   end

   task automatic drive(input bit l_n, input int dv, input bit ep, input bit et);
      @(negedge clk);
      ld_n = l_n; d = 4'(dv); p = ep; t = et;
   endtask

   logic [15:0] lf = 16'hACE1;

   initial begin
      clr_n = 1'b0; ld_n = 1'b1; d = '0; p = 1'b0; t = 1'b0;
      c_ld_n = 1'b1; c_d = '0; c_p = 1'b0; c_t = 1'b0;
      @(negedge clk); @(negedge clk);
      // R1 reset state
      chk(q == 4'd0, "R1", int'(q), 0);
      chk({q2, q1, q0} == 12'd0, "R1", int'({q2, q1, q0}), 0);
      clr_n = 1'b1;
      active = 1'b1;

      // R2 load with enables low and high
      drive(1'b0, 4'hA, 1'b0, 1'b0);
      drive(1'b0, 4'h6, 1'b1, 1'b1);
      // R3/R4 count through the wrap
      for (int i = 0; i < 12; i++) drive(1'b1, 0, 1'b1, 1'b1);
      // R5 hold with each enable low
      for (int i = 0; i < 3; i++) drive(1'b1, 0, 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) drive(1'b1, 0, 1'b1, 1'b0);
      // R6 carry at all ones with count enable low, then chain enable toggled
      drive(1'b0, 4'hF, 1'b0, 1'b1);
      drive(1'b1, 0, 1'b0, 1'b1);
      drive(1'b1, 0, 1'b0, 1'b0);
      drive(1'b1, 0, 1'b1, 1'b1);

      // R1 asynchronous clear mid-cycle, overriding load and enables
      drive(1'b0, 4'h9, 1'b1, 1'b1);
      #3 clr_n = 1'b0;
      #1 chk(q == 4'd0, "R1", int'(q), 0);
      @(negedge clk);
      chk(q == 4'd0, "R1", int'(q), 0);
      clr_n = 1'b1;

      // R7 chain rollover
      @(negedge clk);
      c_ld_n = 1'b0; c_d = 12'hFFC; c_p = 1'b1; c_t = 1'b1;
      @(negedge clk);
      c_ld_n = 1'b1;
      for (int i = 0; i < 6; i++) @(negedge clk);
      c_p = 1'b0;
      @(negedge clk); @(negedge clk);
      c_p = 1'b1;
      c_ld_n = 1'b0; c_d = 12'h0FE;
      @(negedge clk);
      c_ld_n = 1'b1;
      for (int i = 0; i < 4; i++) @(negedge clk);

      // mixed pseudo-random traffic on both
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         clr_n  = (lf[7:0] != 8'h00);
         ld_n   = (lf[4:2] != 3'b000);
         d      = lf[11:8];
         p      = lf[1] | lf[5];
         t      = lf[3] | lf[9];
         c_ld_n = (lf[15:12] != 4'h0);
         c_d    = {lf[3:0], lf[15:8]} | 12'hF00;
         c_p    = lf[6] | lf[2];
         c_t    = lf[14] | lf[0];
      end
      @(negedge clk);
      active = 1'b0;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(20 * 100000);
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule